// File: doc/BRIEF.md
# Quadrature Position Counter with Index Plausibility Filter

This block tracks the angular position of an incremental quadrature encoder inside one mechanical revolution. The two phase inputs are synchronised, cleaned by a digital glitch filter and decoded at four counts per cycle into up and down steps. A position register moves by one count per step and wraps between zero and the revolution length minus one. The revolution length is a run-time input, so one netlist serves encoders of different resolution.

The index input re-zeroes the position, but not blindly. The first qualified index zeroes the count and sets a lock flag. After that, an index is honoured only when the count already sits within one twentieth of a revolution of zero. An index outside that band leaves the count alone and adds to a miss counter. More than five misses in a row drop the lock, and the next qualified index is then taken without question. An index is qualified only if the line is still high a set number of clocks after its rising edge.

Top module: `qenc_index_tracker`

## Requirements
- R1: `pos_count` stays in 0 .. `rev_counts`-1. A step up from `rev_counts`-1 gives 0, and a step down from 0 gives `rev_counts`-1.
- R2: Phases are read as the pair {A,B}. The order 00→10→11→01→00 (A leads) counts up by one on every transition, and the reverse order counts down by one.
- R3: A transition in which A and B both change in the same filtered sample leaves `pos_count` unchanged.
- R4: A level on A or B that holds for fewer than `FILT_LEN` clock samples has no effect on `pos_count`.
- R5: An index is qualified only if the synchronised line is still high `IDX_CONFIRM` clocks after its rising edge. A shorter pulse changes no output.
- R6: While `idx_locked` is 0, a qualified index sets `pos_count` to 0 and `idx_locked` to 1, and clears `bad_idx_count`. This zeroing wins over a step in the same cycle.
- R7: While `idx_locked` is 1, a qualified index with `pos_count` > `rev_counts`-w or `pos_count` < w, where w = `rev_counts`/20 (integer), sets `pos_count` to 0 and clears `bad_idx_count`. This zeroing also wins over a step in the same cycle.
- R8: While `idx_locked` is 1, a qualified index outside that band leaves `pos_count` unchanged and increments `bad_idx_count`, which saturates at its maximum. When the new value exceeds 5, `idx_locked` goes to 0.
- R9: After reset, `pos_count`, `idx_locked` and `bad_idx_count` are all 0.
- R10: A new `rev_counts` value takes effect on the next step. The wrap points follow the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| enc_a | input | 1 | Phase A, asynchronous |
| enc_b | input | 1 | Phase B, asynchronous |
| enc_idx | input | 1 | Index line, asynchronous |
| rev_counts | input | CNT_W | Counts per revolution |
| pos_count | output | CNT_W | Position within the revolution |
| idx_locked | output | 1 | An index has been accepted and the lock still holds |
| bad_idx_count | output | BAD_W | Consecutive implausible index pulses |

## Verification
A wrong decoder phase or filter state shows up as a wrong `pos_count` within one filtered step. The bench therefore compares the position after every single transition, not only after long runs. A wrong lock or miss-counter state stays hidden until the next qualified index. That index then either zeroes a position it should have kept, or keeps one it should have zeroed. For this reason the bench places index pulses both inside and outside the band, at both ends of the wrap, and checks all three outputs after each pulse.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

   // Position of an {A,B} pair along the forward (A leads) sequence.
   function automatic logic [1:0] phase_of(input logic [1:0] ab);
      case (ab)
         2'b00:   phase_of = 2'd0;
         2'b10:   phase_of = 2'd1;
         2'b11:   phase_of = 2'd2;
         default: phase_of = 2'd3;
      endcase
   endfunction

   typedef enum logic [1:0] {
      IDX_IDLE = 2'd0,
      IDX_WAIT = 2'd1
   } idx_state_e;

endpackage

// File: rtl/qenc_input_cond.sv
module qenc_input_cond #(
   parameter int FILT_LEN = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_in,
   output logic clean_out
);
   localparam int CW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;

   logic       sync_q1, sync_q2;
   logic [CW-1:0] run_cnt;

   generate
      if (FILT_LEN < 1) begin : g_bad_len
         $error("FILT_LEN must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q1 <= 1'b0;
         sync_q2 <= 1'b0;
      end else begin
         sync_q1 <= raw_in;
         sync_q2 <= sync_q1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_cnt   <= '0;
         clean_out <= 1'b0;
      end else if (sync_q2 != clean_out) begin
         if (run_cnt == CW'(FILT_LEN - 1)) begin
            clean_out <= sync_q2;
            run_cnt   <= '0;
         end else begin
            run_cnt <= run_cnt + CW'(1);
         end
      end else begin
         run_cnt <= '0;
      end
   end
endmodule

// File: rtl/qenc_step_decode.sv
module qenc_step_decode
   import qenc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] ab_clean,
   output logic       step_up,
   output logic       step_dn
);
   logic [1:0] ab_prev;
   logic [1:0] ph_now, ph_old;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ab_prev <= 2'b00;
      else        ab_prev <= ab_clean;
   end

   always_comb begin
      ph_now  = phase_of(ab_clean);
      ph_old  = phase_of(ab_prev);
      step_up = (ph_now == ph_old + 2'd1);
      step_dn = (ph_old == ph_now + 2'd1);
   end
endmodule

// File: rtl/qenc_index_qual.sv
module qenc_index_qual
   import qenc_pkg::*;
#(
   parameter int IDX_CONFIRM = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic idx_raw,
   output logic idx_valid
);
   localparam int TW = $clog2(IDX_CONFIRM + 1);

   logic          s1, s2, s3;
   logic [TW-1:0] hold_tmr;
   idx_state_e    st;

   generate
      if (IDX_CONFIRM < 1) begin : g_bad_confirm
         $error("IDX_CONFIRM must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1 <= 1'b0;
         s2 <= 1'b0;
         s3 <= 1'b0;
      end else begin
         s1 <= idx_raw;
         s2 <= s1;
         s3 <= s2;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= IDX_IDLE;
         hold_tmr  <= '0;
         idx_valid <= 1'b0;
      end else begin
         idx_valid <= 1'b0;
         case (st)
            IDX_IDLE: begin
               if (s2 && !s3) begin
                  st       <= IDX_WAIT;
                  hold_tmr <= TW'(IDX_CONFIRM);
               end
            end
            default: begin
               if (hold_tmr == TW'(1)) begin
                  st        <= IDX_IDLE;
                  idx_valid <= s2;
               end
               hold_tmr <= hold_tmr - TW'(1);
            end
         endcase
      end
   end
endmodule

// File: rtl/qenc_index_tracker.sv
module qenc_index_tracker #(
   parameter int CNT_W       = 16,
   parameter int BAD_W       = 3,
   parameter int BAD_LIMIT   = 5,
   parameter int WIN_DIV     = 20,
   parameter int FILT_LEN    = 3,
   parameter int IDX_CONFIRM = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enc_a,
   input  logic             enc_b,
   input  logic             enc_idx,
   input  logic [CNT_W-1:0] rev_counts,
   output logic [CNT_W-1:0] pos_count,
   output logic             idx_locked,
   output logic [BAD_W-1:0] bad_idx_count
);
   localparam logic [BAD_W-1:0] BAD_MAX = {BAD_W{1'b1}};

   generate
      if (BAD_LIMIT + 1 > (1 << BAD_W) - 1) begin : g_bad_w
         $error("BAD_W too narrow for BAD_LIMIT");
      end
      if (WIN_DIV < 1) begin : g_bad_div
         $error("WIN_DIV must be positive");
      end
   endgenerate

   logic [1:0] raw_ab, clean_ab;
   logic       step_up, step_dn, idx_valid;

   assign raw_ab = {enc_a, enc_b};

   genvar g;
   generate
      for (g = 0; g < 2; g++) begin : g_phase
         qenc_input_cond #(.FILT_LEN(FILT_LEN)) u_cond (
            .clk       (clk),
            .rst_n     (rst_n),
            .raw_in    (raw_ab[g]),
            .clean_out (clean_ab[g])
         );
      end
   endgenerate

   qenc_step_decode u_dec (
      .clk      (clk),
      .rst_n    (rst_n),
      .ab_clean (clean_ab),
      .step_up  (step_up),
      .step_dn  (step_dn)
   );

   qenc_index_qual #(.IDX_CONFIRM(IDX_CONFIRM)) u_idx (
      .clk       (clk),
      .rst_n     (rst_n),
      .idx_raw   (enc_idx),
      .idx_valid (idx_valid)
   );

   logic [CNT_W-1:0] band;
   logic             in_band;
   logic [BAD_W-1:0] bad_next;
   logic [CNT_W-1:0] top_val;

   always_comb begin
      band     = rev_counts / CNT_W'(WIN_DIV);
      in_band  = (pos_count > rev_counts - band) || (pos_count < band);
      bad_next = (bad_idx_count == BAD_MAX) ? BAD_MAX : bad_idx_count + BAD_W'(1);
      top_val  = rev_counts - CNT_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_count     <= '0;
         idx_locked    <= 1'b0;
         bad_idx_count <= '0;
      end else if (idx_valid) begin
         if (!idx_locked || in_band) begin
            pos_count     <= '0;
            idx_locked    <= 1'b1;
            bad_idx_count <= '0;
         end else begin
            bad_idx_count <= bad_next;
            if (bad_next > BAD_W'(BAD_LIMIT)) idx_locked <= 1'b0;
         end
      end else if (step_up) begin
         pos_count <= (pos_count >= top_val) ? '0 : pos_count + CNT_W'(1);
      end else if (step_dn) begin
         pos_count <= (pos_count == '0 || pos_count > top_val) ? top_val
                                                               : pos_count - CNT_W'(1);
      end
   end
endmodule

// File: rtl/qenc_index_tracker_chk.sv
module qenc_index_tracker_chk #(
   parameter int CNT_W = 16,
   parameter int BAD_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CNT_W-1:0] rev_counts,
   input logic [CNT_W-1:0] pos_count,
   input logic             idx_locked,
   input logic [BAD_W-1:0] bad_idx_count,
   input logic             step_up,
   input logic             step_dn,
   input logic             idx_valid
);
   p_in_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (pos_count < rev_counts && $stable(rev_counts) && rev_counts != '0)
         |=> (pos_count < rev_counts) || !$stable(rev_counts));

   p_up_by_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (step_up && !idx_valid && pos_count < rev_counts - CNT_W'(1))
         |=> pos_count == $past(pos_count) + CNT_W'(1));

   p_one_dir_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(step_up && step_dn));

   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!step_up && !step_dn && !idx_valid) |=> $stable(pos_count));

   p_first_idx_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (idx_valid && !idx_locked)
         |=> (pos_count == '0 && idx_locked && bad_idx_count == '0));

   p_bad_mono_r8: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (bad_idx_count == $past(bad_idx_count)) ||
               (bad_idx_count == $past(bad_idx_count) + BAD_W'(1)) ||
               (bad_idx_count == '0));

   p_bad_needs_idx_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !idx_valid |=> $stable(bad_idx_count) && $stable(idx_locked));
endmodule

bind qenc_index_tracker qenc_index_tracker_chk #(.CNT_W(CNT_W), .BAD_W(BAD_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .rev_counts    (rev_counts),
   .pos_count     (pos_count),
   .idx_locked    (idx_locked),
   .bad_idx_count (bad_idx_count),
   .step_up       (step_up),
   .step_dn       (step_dn),
   .idx_valid     (idx_valid)
);

// File: tb/qenc_index_tracker_bench.sv
module qenc_index_tracker_bench;
   localparam int CNT_W = 16;
   localparam int BAD_W = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic enc_a = 1'b0, enc_b = 1'b0, enc_idx = 1'b0;
   logic [CNT_W-1:0] rev_counts = 16'd100;
   logic [CNT_W-1:0] pos_count;
   logic             idx_locked;
   logic [BAD_W-1:0] bad_idx_count;

   always #10 clk = ~clk;

   qenc_index_tracker u_qenc_index_tracker (
      .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b), .enc_idx(enc_idx),
      .rev_counts(rev_counts), .pos_count(pos_count), .idx_locked(idx_locked),
      .bad_idx_count(bad_idx_count)
   );

   typedef struct {
      int    cnt;
      bit    lk;
      int    bad;
      string tag;
   } exp_t;

   exp_t  sb[$];
   int    total = 0;
   int    bad   = 0;
   bit    done  = 0;

   int    m_cnt = 0;
   bit    m_lk  = 0;
   int    m_bad = 0;
   int    ph    = 0;

   task automatic expect_now(input string tag);
      exp_t e;
      e.cnt = m_cnt; e.lk = m_lk; e.bad = m_bad; e.tag = tag;
      sb.push_back(e);
   endtask

   task automatic set_phase(input int p);
      @(negedge clk);
      case (p)
         0: begin enc_a = 1'b0; enc_b = 1'b0; end
         1: begin enc_a = 1'b1; enc_b = 1'b0; end
         2: begin enc_a = 1'b1; enc_b = 1'b1; end
         default: begin enc_a = 1'b0; enc_b = 1'b1; end
      endcase
      repeat (12) @(negedge clk);
   endtask

   task automatic step(input bit up, input string tag);
      ph = up ? (ph + 1) % 4 : (ph + 3) % 4;
      set_phase(ph);
      if (up) m_cnt = (m_cnt >= int'(rev_counts) - 1) ? 0 : m_cnt + 1;
      else    m_cnt = (m_cnt == 0) ? int'(rev_counts) - 1 : m_cnt - 1;
      expect_now(tag);
   endtask

   task automatic index_pulse(input int width, input string tag);
      int w;
      @(negedge clk);
      enc_idx = 1'b1;
      repeat (width) @(negedge clk);
      enc_idx = 1'b0;
      repeat (15) @(negedge clk);
      if (width >= 8) begin
         w = int'(rev_counts) / 20;
         if (!m_lk || m_cnt > int'(rev_counts) - w || m_cnt < w) begin
            m_cnt = 0; m_lk = 1; m_bad = 0;
         end else begin
            if (m_bad < 7) m_bad = m_bad + 1;
            if (m_bad > 5) m_lk = 0;
         end
      end
      expect_now(tag);
   endtask

   // monitor
   initial begin
      forever begin
         @(negedge clk);
         while (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            total++;
            if (int'(pos_count) != e.cnt || idx_locked != e.lk || int'(bad_idx_count) != e.bad) begin
               bad++;
               $display("FAIL %s: got cnt=%0d lock=%0d bad=%0d, want cnt=%0d lock=%0d bad=%0d",
                        e.tag, pos_count, idx_locked, bad_idx_count, e.cnt, e.lk, e.bad);
            end
         end
      end
   end

   // watchdog
   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: got running, want finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   // driver
   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      expect_now("R9 reset state");

      for (int i = 0; i < 10; i++) step(1'b1, "R2 count up");
      for (int i = 0; i < 12; i++) step(1'b0, "R1 R2 count down and wrap below zero");

      // R4: one-clock glitch on A
      @(negedge clk);
      enc_a = ~enc_a;
      @(negedge clk);
      enc_a = ~enc_a;
      repeat (12) @(negedge clk);
      expect_now("R4 short glitch ignored");

      // R3: both phases flip together
      ph = (ph + 2) % 4;
      set_phase(ph);
      expect_now("R3 double transition ignored");

      index_pulse(2, "R5 short index ignored");
      index_pulse(20, "R6 first index zeroes and locks");

      for (int i = 0; i < 3; i++) step(1'b1, "R2 count up after lock");
      index_pulse(20, "R7 in-band index near low end");
      for (int i = 0; i < 2; i++) step(1'b0, "R1 wrap after lock");
      index_pulse(20, "R7 in-band index near high end");

      for (int i = 0; i < 50; i++) step(1'b1, "R2 long run up");
      for (int i = 0; i < 6; i++) index_pulse(20, "R8 out-of-band index");
      index_pulse(20, "R6 relock after lock lost");

      @(negedge clk);
      rev_counts = 16'd40;
      step(1'b0, "R10 new length wrap down");
      step(1'b1, "R10 new length wrap up");
      for (int i = 0; i < 5; i++) step(1'b1, "R10 up in new length");
      index_pulse(20, "R8 R10 band follows new length");

      repeat (5) @(negedge clk);
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule